// File: doc/BRIEF.md
# Shared GPIO Interrupt Request Combiner

This block folds the interrupt conditions of a group of general-purpose input pins into a single request line for the interrupt controller. Every pin is first brought into the clock domain by a two-stage synchroniser. It is then compared against its own polarity choice and masked by its own enable bit. The surviving conditions are ORed together. A rising edge of that OR, found by comparing it with a registered copy, sets one shared pending flag.

The request seen by the interrupt controller is the pending flag qualified by a global enable register. Software loads that register through a write strobe. An acknowledge strobe clears both the pending flag and the global enable in hardware, while the per-pin settings stay untouched. Because a single OR feeds a single edge detector, a pin that remains active hides every other pin until the OR drops. The block does not rank pins and does not record which one fired, so the interrupt service routine has to poll the pins.

Top module: `gpio_irq_combiner`

## Requirements
- R1: When a pin's polarity select is 1, a high synchronised level is its active state, so a low-to-high change triggers. When the select is 0, a low level is active, so a high-to-low change triggers.
- R2: A pin whose enable bit is 0 never contributes, whatever its level. Setting the enable while that pin is active raises the request on the next clock edge.
- R3: A change on a pin input shows up on `irqOut` on the third rising clock edge after it is applied: two synchroniser stages, then the pending flag.
- R4: While any enabled pin is active, another pin becoming active produces no new request, even after an acknowledge has cleared the earlier one.
- R5: If the active pin is disabled for at least one cycle and then enabled again while still active, a new request is raised on the edge after the re-enable.
- R6: An acknowledge clears the pending flag and the global enable on the next clock edge.
- R7: If a new OR rising edge occurs in the same cycle as an acknowledge, the pending flag stays set.
- R8: A write strobe loads the global enable from the data input, and an acknowledge in the same cycle wins and clears it. A pending flag held while the global enable is 0 is kept, and it drives `irqOut` once the global enable is written to 1.
- R9: A synchronous active-high reset clears the pending flag, the OR history and the global enable, so `irqOut` and `globalEnable` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pinLevel | input | PIN_COUNT | Asynchronous pin levels |
| pinRiseSel | input | PIN_COUNT | Per-pin polarity: 1 = active high, 0 = active low |
| pinEnable | input | PIN_COUNT | Per-pin interrupt enable |
| globalEnWrite | input | 1 | Strobe that loads the global enable |
| globalEnData | input | 1 | Value loaded by the write strobe |
| intAck | input | 1 | Interrupt acknowledge strobe |
| irqOut | output | 1 | Shared interrupt request |
| globalEnable | output | 1 | Current global enable (cleared by acknowledge) |

## Verification
The bench targets the masking behaviour. A second pin becoming active while the first is held must stay silent; a design that detected per-pin edges would fire there. It drops and restores the enable of a held pin to show that the request comes back. A design that latched levels instead of the OR edge would never re-fire, or would fire constantly. An edge coinciding with an acknowledge is checked because a design that gives the clear priority loses that event. An acknowledge coinciding with a write is checked because a design that gives the write priority leaves the global enable set. The pipeline delay is sampled exactly, so a missing or extra synchroniser stage shows up as a request one cycle early or late. The falling-trigger polarity is also exercised.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic setPending;
    logic clrPending;
    logic clrGlobal;
    logic loadGlobal;
    logic globalData;
  } irqStrobes_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIN_COUNT-1:0] pinLevel,
  input  logic [PIN_COUNT-1:0] pinRiseSel,
  input  logic [PIN_COUNT-1:0] pinEnable,
  input  irqStrobes_t          strobes,
  output logic                 edgeSeen,
  output logic                 pendingQ,
  output logic                 globalEnQ
);

  logic [PIN_COUNT-1:0] pinSync;
  logic [PIN_COUNT-1:0] qualified;
  logic                 anyActive;
  logic                 anyActiveQ;

  gpio_irq_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) syncInst (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(pinLevel),
    .syncOut(pinSync)
  );

  // Polarity adjust and mask per pin
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_qual
    assign qualified[p] = pinEnable[p] & (pinRiseSel[p] ? pinSync[p] : ~pinSync[p]);
  end

  assign anyActive = |qualified;
  assign edgeSeen  = anyActive & ~anyActiveQ;

  always_ff @(posedge clk) begin
    if (rst) anyActiveQ <= 1'b0;
    else     anyActiveQ <= anyActive;
  end

  always_ff @(posedge clk) begin
    if (rst)                     pendingQ <= 1'b0;
    else if (strobes.setPending) pendingQ <= 1'b1;
    else if (strobes.clrPending) pendingQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                     globalEnQ <= 1'b0;
    else if (strobes.clrGlobal)  globalEnQ <= 1'b0;
    else if (strobes.loadGlobal) globalEnQ <= strobes.globalData;
  end

  // A detected OR edge always leaves the flag set (R3, R7)
  assert_edge_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
    edgeSeen |=> pendingQ);

  // The flag moves only on an edge or a clear strobe (R4)
  assert_flag_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!edgeSeen && !strobes.clrPending) |=> $stable(pendingQ));

endmodule

// File: rtl/gpio_irq_control.sv
module gpio_irq_control
  import gpio_irq_pkg::*;
(
  input  logic        edgeSeen,
  input  logic        intAck,
  input  logic        globalEnWrite,
  input  logic        globalEnData,
  output irqStrobes_t strobes
);

  always_comb begin
    strobes.setPending = edgeSeen;
    strobes.clrPending = intAck & ~edgeSeen;   // a fresh edge beats the clear
    strobes.clrGlobal  = intAck;               // hardware clear beats software write
    strobes.loadGlobal = globalEnWrite & ~intAck;
    strobes.globalData = globalEnData;
  end

endmodule

// File: rtl/gpio_irq_combiner.sv
module gpio_irq_combiner
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIN_COUNT-1:0] pinLevel,
  input  logic [PIN_COUNT-1:0] pinRiseSel,
  input  logic [PIN_COUNT-1:0] pinEnable,
  input  logic                 globalEnWrite,
  input  logic                 globalEnData,
  input  logic                 intAck,
  output logic                 irqOut,
  output logic                 globalEnable
);

  irqStrobes_t strobes;
  logic        edgeSeen;
  logic        pendingQ;
  logic        globalEnQ;

  gpio_irq_datapath #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) dp (
    .clk       (clk),
    .rst       (rst),
    .pinLevel  (pinLevel),
    .pinRiseSel(pinRiseSel),
    .pinEnable (pinEnable),
    .strobes   (strobes),
    .edgeSeen  (edgeSeen),
    .pendingQ  (pendingQ),
    .globalEnQ (globalEnQ)
  );

  gpio_irq_control ctl (
    .edgeSeen     (edgeSeen),
    .intAck       (intAck),
    .globalEnWrite(globalEnWrite),
    .globalEnData (globalEnData),
    .strobes      (strobes)
  );

  assign irqOut       = pendingQ & globalEnQ;
  assign globalEnable = globalEnQ;

  // Acknowledge drops the global enable (R6, R8)
  assert_ack_clears_enable_R6: assert property (@(posedge clk) disable iff (rst)
    intAck |=> !globalEnable);

  // Acknowledge without a new edge leaves no request (R6)
  assert_ack_clears_request_R6: assert property (@(posedge clk) disable iff (rst)
    (intAck && !edgeSeen) |=> !irqOut);

  // Global enable changes only through write or acknowledge (R8)
  assert_enable_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!intAck && !globalEnWrite) |=> $stable(globalEnable));

endmodule

// File: tb/gpio_irq_combiner_test.sv
module gpio_irq_combiner_test;

  localparam int N  = 4;
  localparam int NV = 28;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] pinLevel, pinRiseSel, pinEnable;
  logic         globalEnWrite, globalEnData, intAck;
  logic         irqOut, globalEnable;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  gpio_irq_combiner #(.PIN_COUNT(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .pinLevel(pinLevel), .pinRiseSel(pinRiseSel),
    .pinEnable(pinEnable), .globalEnWrite(globalEnWrite),
    .globalEnData(globalEnData), .intAck(intAck),
    .irqOut(irqOut), .globalEnable(globalEnable)
  );

  // {pins, polarity, enable, write, data, ack, expIrq, expGlobal}
  localparam logic [16:0] VEC [NV] = '{
    17'b0000_1111_0001_1_1_0_0_1, //  0 R8 write enable
    17'b0001_1111_0001_0_0_0_0_1, //  1 R3 sync stage 1
    17'b0001_1111_0001_0_0_0_0_1, //  2 R3 sync stage 2
    17'b0001_1111_0001_0_0_0_1_1, //  3 R3 request on third edge
    17'b0001_1111_0001_0_0_1_0_0, //  4 R6 acknowledge
    17'b0011_1111_0011_1_1_0_0_1, //  5 R4 second pin rises
    17'b0011_1111_0011_0_0_0_0_1, //  6 R4
    17'b0011_1111_0011_0_0_0_0_1, //  7 R4 masked by held pin
    17'b0011_1111_0000_0_0_0_0_1, //  8 R5 disable both
    17'b0011_1111_0001_0_0_0_1_1, //  9 R5 re-enable retriggers
    17'b0011_1111_0001_0_0_1_0_0, // 10 R6
    17'b0011_1111_0000_0_0_0_0_0, // 11 R5 drop
    17'b0011_1111_0001_1_1_1_0_0, // 12 R7 edge with ack, R8 ack beats write
    17'b0011_1111_0001_1_1_0_1_1, // 13 R7 flag kept, R8 shows when enabled
    17'b0000_1111_0000_0_0_1_0_0, // 14 R6
    17'b0000_1011_0000_1_1_0_0_1, // 15 R1 pin2 active low
    17'b0000_1011_0100_0_0_0_1_1, // 16 R1 low pin active on enable
    17'b0000_1011_0100_0_0_1_0_0, // 17 R6
    17'b0100_1011_0100_1_1_0_0_1, // 18 R1 pin2 goes high
    17'b0100_1011_0100_0_0_0_0_1, // 19
    17'b0100_1011_0100_0_0_0_0_1, // 20
    17'b0000_1011_0100_0_0_0_0_1, // 21 R1 falling change
    17'b0000_1011_0100_0_0_0_0_1, // 22
    17'b0000_1011_0100_0_0_0_1_1, // 23 R1 falling triggers
    17'b1111_1111_0000_0_0_1_0_0, // 24 R6
    17'b1111_1111_0000_1_1_0_0_1, // 25 R2 all high, all masked
    17'b1111_1111_0000_0_0_0_0_1, // 26 R2
    17'b1111_1111_0000_0_0_0_0_1  // 27 R2
  };
  localparam int VREQ [NV] = '{8,3,3,3,6,4,4,4,5,5,6,5,7,7,6,1,1,6,1,1,1,1,1,1,6,2,2,2};

  task automatic check(input string req, input int idx, input logic act, input logic exp, input string what);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s step %0d %s: actual %b expected %b", req, idx, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rst = 1'b1; pinLevel = '0; pinRiseSel = '1; pinEnable = '0;
    globalEnWrite = 1'b0; globalEnData = 1'b0; intAck = 1'b0;
    repeat (3) step();
    check("R9", -1, irqOut, 1'b0, "irq after reset");
    check("R9", -1, globalEnable, 1'b0, "global after reset");
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {pinLevel, pinRiseSel, pinEnable, globalEnWrite, globalEnData, intAck} = VEC[i][16:2];
      step();
      check($sformatf("R%0d", VREQ[i]), i, irqOut, VEC[i][1], "irq");
      check($sformatf("R%0d", VREQ[i]), i, globalEnable, VEC[i][0], "global");
    end

    // R2: enabling held-active pins raises the request one edge later
    @(negedge clk);
    globalEnWrite = 1'b0; intAck = 1'b0; pinEnable = 4'b1111;
    step();
    check("R2", 100, irqOut, 1'b1, "enable while active");

    // R9: reset clears request and global enable
    @(negedge clk); rst = 1'b1;
    step();
    check("R9", 101, irqOut, 1'b0, "irq in reset");
    check("R9", 101, globalEnable, 1'b0, "global in reset");
    @(negedge clk); rst = 1'b0;
    step();
    step();
    check("R9", 102, irqOut, 1'b0, "irq after reset, enable cleared");
    check("R9", 102, globalEnable, 1'b0, "global stays cleared");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule